// File: doc/BRIEF.md
# Mixed-Width Byte-Serial Register Port

This block is the register-side front end of a two-wire serial slave. A byte-level engine in front of it delivers frame boundaries (start, repeated start, stop), written bytes, and requests for read bytes. The port first collects a 16-bit register pointer, high byte first. From the pointer value it decides whether the target register is 16 or 32 bits wide. It then packs incoming bytes into a register word, or unpacks a register word into outgoing bytes, using a halfword-swapped byte order.

Behind the port sit three small register banks. Two banks hold 16-bit registers and one holds 32-bit registers. There is also a 16-bit link control register that software cannot write directly. That control register changes only through an indirect write port: a 32-bit word that names a target, an operation (set or clear), and a 16-bit bit mask. The control register drives the link setup: bit 15 picks the link mode, bit 7 the transmit mode, bit 5 keeps the high-speed clock running, bits [2:1] hold the lane count minus one, and bit 0 suppresses end-of-transmission packets.

A controller that wants to read a register writes the pointer in one frame, issues a repeated start, and reads. The pointer is retained across the repeated start, and both reads and writes may burst over consecutive registers.

Top module: `mixw_reg_port`

FSM states: `S_IDLE` (outside a frame), `S_ADDR_HI` (expecting the pointer high byte or a read), `S_ADDR_LO` (expecting the pointer low byte), `S_DATA_WR` (collecting write bytes), `S_DATA_RD` (returning read bytes). Transitions:
- stop → `S_IDLE` from any state.
- start → `S_ADDR_HI` from any state.
- In `S_ADDR_HI`, a byte moves to `S_ADDR_LO`, and a read request moves to `S_DATA_RD`.
- In `S_ADDR_LO`, a byte moves to `S_DATA_WR`.
- The data states hold until the next start or stop.

## Requirements
- R1: A frame begins with two pointer bytes, high byte first. Data bytes follow and target the register at that pointer.
- R2: Pointers below 0x0100 or at/above 0x0600 select 16-bit registers that take 2 data bytes. Every other pointer selects a 32-bit register that takes 4 data bytes.
- R3: Write data bytes land in the register in this order: byte 0 → bits [15:8], byte 1 → [7:0], byte 2 → [31:24], byte 3 → [23:16]. The register changes only when its last byte arrives.
- R4: Read bytes use the same order as R3. Each read byte appears on rd_byte with rd_valid high in the cycle after the rd_req cycle.
- R5: Mapped registers are: 16-bit at 0x0000–0x0006 and at 0x0600–0x0606 (step 2), and 32-bit at 0x0200–0x020C (step 4). Any other pointer reads as zero and ignores writes; the indirect port 0x0500 also reads as zero.
- R6: A 32-bit write to 0x0500 with target field [28:24] = 3 changes the control register. Operation field [31:29] = 5 sets the bits given by mask [15:0], and 6 clears them. Any other target or operation leaves the control register unchanged.
- R7: The control register is readable at 0x040C as a 32-bit word with zero upper half, and it is always visible on ctrl_word. Direct writes to 0x040C have no effect.
- R8: A frame that ends by stop or repeated start before a register's last byte arrives leaves that register unchanged.
- R9: After each completed register, the pointer advances by that register's width in bytes. The width is decided afresh for each register in a burst.
- R10: A read that starts right after a start, with no pointer bytes, reads from the retained pointer.
- R11: Bytes and read requests outside a frame are ignored: no register changes and rd_valid stays low.
- R12: After reset, all registers and ctrl_word are zero and rd_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_start | input | 1 | Start or repeated start, one-cycle pulse |
| xfer_stop | input | 1 | Stop, one-cycle pulse |
| wr_valid | input | 1 | A written byte is present on wr_byte |
| wr_byte | input | 8 | Written byte |
| rd_req | input | 1 | Request for the next read byte |
| rd_valid | output | 1 | rd_byte holds a read byte |
| rd_byte | output | 8 | Read byte |
| ctrl_word | output | 16 | Link control register |

## Verification
The assertions check several properties on every cycle:
- a read byte is never presented without a request one cycle earlier;
- a stop always returns the port to idle;
- the byte index of a 16-bit register never goes past its second byte;
- the pointer advances by exactly the register width on each commit;
- the control word moves only on an indirect write, and nothing is returned outside a frame.

Only the directed scenarios can show the data-level behaviour:
- the swapped byte order;
- the width switch inside a burst that crosses 0x0600;
- discard of partial words;
- set/clear masking with rejected targets and operations;
- read-back from the retained pointer after a repeated start.

// File: rtl/mixw_pkg.sv
package mixw_pkg;

    localparam int          PTR_W      = 16;
    localparam int          WORD_W     = 32;
    localparam int          CTRL_W     = 16;
    localparam logic [15:0] WIDE_FIRST = 16'h0100;
    localparam logic [15:0] WIDE_END   = 16'h0600;
    localparam logic [15:0] IND_PTR    = 16'h0500;
    localparam logic [15:0] CTRL_PTR   = 16'h040C;
    localparam logic [2:0]  OP_SET     = 3'd5;
    localparam logic [2:0]  OP_CLR     = 3'd6;
    localparam logic [4:0]  TGT_CTRL   = 5'd3;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR_HI,
        S_ADDR_LO,
        S_DATA_WR,
        S_DATA_RD
    } xfer_state_e;

    function automatic logic is_wide(input logic [15:0] p);
        return (p >= WIDE_FIRST) && (p < WIDE_END);
    endfunction

    // byte k of a register word in wire order
    function automatic logic [7:0] wire_byte(input logic [31:0] w, input logic [1:0] k);
        logic [7:0] b;
        unique case (k)
            2'd0:    b = w[15:8];
            2'd1:    b = w[7:0];
            2'd2:    b = w[31:24];
            default: b = w[23:16];
        endcase
        return b;
    endfunction

endpackage

// File: rtl/mixw_reg_bank.sv
module mixw_reg_bank #(
    parameter int BASE   = 0,
    parameter int STRIDE = 2,
    parameter int DEPTH  = 4,
    parameter int WIDTH  = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] addr,
    input  logic        we,
    input  logic [31:0] wdata,
    output logic        hit,
    output logic [31:0] rdata
);
    localparam int SH   = $clog2(STRIDE);
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int SPAN = DEPTH * STRIDE;

    logic [15:0]      off;
    logic [IW-1:0]    idx;
    logic [WIDTH-1:0] mem [DEPTH];

    assign off = addr - 16'(BASE);
    assign idx = off[SH+IW-1:SH];
    assign hit = (addr >= 16'(BASE)) && (off < 16'(SPAN)) && (off[SH-1:0] == '0);

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem[g] <= '0;
            end else if (we && hit && (idx == IW'(g))) begin
                mem[g] <= wdata[WIDTH-1:0];
            end
        end
    end

    assign rdata = hit ? 32'(mem[idx]) : 32'h0;

endmodule

// File: rtl/mixw_ctrl_setclr.sv
module mixw_ctrl_setclr
    import mixw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [31:0]       wdata,
    output logic [CTRL_W-1:0] ctrl
);
    logic [2:0]        op;
    logic [4:0]        tgt;
    logic [CTRL_W-1:0] mask;

    assign op   = wdata[31:29];
    assign tgt  = wdata[28:24];
    assign mask = wdata[CTRL_W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (we && (tgt == TGT_CTRL)) begin
            if (op == OP_SET) begin
                ctrl <= ctrl | mask;
            end else if (op == OP_CLR) begin
                ctrl <= ctrl & ~mask;
            end
        end
    end

endmodule

// File: rtl/mixw_reg_port.sv
module mixw_reg_port
    import mixw_pkg::*;
#(
    parameter int NARROW_DEPTH = 4,
    parameter int WIDE_DEPTH   = 4,
    parameter int LO_BASE      = 16'h0000,
    parameter int WIDE_BASE    = 16'h0200,
    parameter int HI_BASE      = 16'h0600
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer_start,
    input  logic              xfer_stop,
    input  logic              wr_valid,
    input  logic [7:0]        wr_byte,
    input  logic              rd_req,
    output logic              rd_valid,
    output logic [7:0]        rd_byte,
    output logic [CTRL_W-1:0] ctrl_word
);
    xfer_state_e state_q, state_d;
    logic [15:0] ptr_q;
    logic [1:0]  idx_q;
    logic [7:0]  hold_q [4];
    logic [31:0] snap_q;

    logic        frame_evt, wide, at_last;
    logic [1:0]  last_idx;
    logic [15:0] step;
    logic        hi_load, lo_load, wr_go, rd_go, commit_w, ind_we;
    logic [31:0] commit_word, live_word;
    logic        lo_hit, w_hit, hi_hit;
    logic [31:0] lo_rdata, w_rdata, hi_rdata;

    assign frame_evt = xfer_start | xfer_stop;
    assign wide      = is_wide(ptr_q);
    assign last_idx  = wide ? 2'd3 : 2'd1;
    assign at_last   = (idx_q == last_idx);
    assign step      = wide ? 16'd4 : 16'd2;

    assign hi_load  = !frame_evt && wr_valid && (state_q == S_ADDR_HI);
    assign lo_load  = !frame_evt && wr_valid && (state_q == S_ADDR_LO);
    assign wr_go    = !frame_evt && wr_valid && (state_q == S_DATA_WR);
    assign rd_go    = !frame_evt && rd_req &&
                      ((state_q == S_DATA_RD) || ((state_q == S_ADDR_HI) && !wr_valid));
    assign commit_w = wr_go && at_last;
    assign ind_we   = commit_w && (ptr_q == IND_PTR);

    assign commit_word = wide ? {hold_q[2], wr_byte, hold_q[0], hold_q[1]}
                              : {16'h0, hold_q[0], wr_byte};

    mixw_reg_bank #(.BASE(LO_BASE), .STRIDE(2), .DEPTH(NARROW_DEPTH), .WIDTH(16)) u_bank_lo (
        .clk(clk), .rst_n(rst_n), .addr(ptr_q), .we(commit_w), .wdata(commit_word),
        .hit(lo_hit), .rdata(lo_rdata));

    mixw_reg_bank #(.BASE(WIDE_BASE), .STRIDE(4), .DEPTH(WIDE_DEPTH), .WIDTH(32)) u_bank_wide (
        .clk(clk), .rst_n(rst_n), .addr(ptr_q), .we(commit_w), .wdata(commit_word),
        .hit(w_hit), .rdata(w_rdata));

    mixw_reg_bank #(.BASE(HI_BASE), .STRIDE(2), .DEPTH(NARROW_DEPTH), .WIDTH(16)) u_bank_hi (
        .clk(clk), .rst_n(rst_n), .addr(ptr_q), .we(commit_w), .wdata(commit_word),
        .hit(hi_hit), .rdata(hi_rdata));

    mixw_ctrl_setclr u_ctrl (
        .clk(clk), .rst_n(rst_n), .we(ind_we), .wdata(commit_word), .ctrl(ctrl_word));

    // banks return zero when not hit, so an OR is a mux
    assign live_word = lo_rdata | w_rdata | hi_rdata |
                       ((ptr_q == CTRL_PTR) ? 32'(ctrl_word) : 32'h0);

    // next state
    always_comb begin
        state_d = state_q;
        if (xfer_stop) begin
            state_d = S_IDLE;
        end else if (xfer_start) begin
            state_d = S_ADDR_HI;
        end else begin
            unique case (state_q)
                S_IDLE:    state_d = S_IDLE;
                S_ADDR_HI: begin
                    if (wr_valid)    state_d = S_ADDR_LO;
                    else if (rd_req) state_d = S_DATA_RD;
                end
                S_ADDR_LO: if (wr_valid) state_d = S_DATA_WR;
                S_DATA_WR: state_d = S_DATA_WR;
                S_DATA_RD: state_d = S_DATA_RD;
                default:   state_d = S_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // pointer, byte index and assembly holding bytes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            idx_q  <= '0;
            snap_q <= '0;
            for (int k = 0; k < 4; k++) hold_q[k] <= '0;
        end else if (frame_evt) begin
            idx_q <= '0;
        end else begin
            if (hi_load) ptr_q[15:8] <= wr_byte;
            if (lo_load) begin
                ptr_q[7:0] <= wr_byte;
                idx_q      <= '0;
            end
            if (wr_go || rd_go) begin
                if (at_last) begin
                    idx_q <= '0;
                    ptr_q <= ptr_q + step;
                end else begin
                    idx_q <= idx_q + 2'd1;
                end
            end
            if (wr_go && !at_last) hold_q[idx_q] <= wr_byte;
            if (rd_go && (idx_q == 2'd0)) snap_q <= live_word;
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_byte  <= '0;
        end else begin
            rd_valid <= rd_go;
            if (rd_go) rd_byte <= wire_byte((idx_q == 2'd0) ? live_word : snap_q, idx_q);
        end
    end

endmodule

// File: rtl/mixw_reg_port_chk.sv
module mixw_reg_port_chk
    import mixw_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              xfer_start,
    input logic              xfer_stop,
    input logic              rd_req,
    input logic              rd_valid,
    input logic [CTRL_W-1:0] ctrl_word,
    input xfer_state_e       state_q,
    input logic [1:0]        idx_q,
    input logic [15:0]       ptr_q,
    input logic              commit_w,
    input logic              ind_we
);
    // R4: a read byte follows a request
    a_r4_valid_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_req));

    // R11: stop always lands in idle
    a_r11_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_stop |=> (state_q == S_IDLE));

    // R11: nothing is read back outside a frame
    a_r11_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == S_IDLE) && !xfer_start) |=> !rd_valid);

    // R2: a 16-bit register never gets past its second byte
    a_r2_narrow_index: assert property (@(posedge clk) disable iff (!rst_n)
        (((state_q == S_DATA_WR) || (state_q == S_DATA_RD)) && !is_wide(ptr_q)) |-> (idx_q < 2'd2));

    // R9: each commit moves the pointer by the register width
    a_r9_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        commit_w |=> (ptr_q == $past(ptr_q) + (is_wide($past(ptr_q)) ? 16'd4 : 16'd2)));

    // R6: the control word moves only on an indirect write
    a_r6_ctrl_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !ind_we |=> $stable(ctrl_word));

    // R8: commits happen only while collecting data
    a_r8_commit_in_data: assert property (@(posedge clk) disable iff (!rst_n)
        commit_w |-> (state_q == S_DATA_WR) && !xfer_start && !xfer_stop);

endmodule

bind mixw_reg_port mixw_reg_port_chk i_chk (
    .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .xfer_stop(xfer_stop),
    .rd_req(rd_req), .rd_valid(rd_valid), .ctrl_word(ctrl_word),
    .state_q(state_q), .idx_q(idx_q), .ptr_q(ptr_q),
    .commit_w(commit_w), .ind_we(ind_we));

// File: tb/test_mixw_reg_port.sv
module test_mixw_reg_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xfer_start = 1'b0, xfer_stop = 1'b0, wr_valid = 1'b0, rd_req = 1'b0;
    logic [7:0]  wr_byte = 8'h00;
    logic        rd_valid;
    logic [7:0]  rd_byte;
    logic [15:0] ctrl_word;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    mixw_reg_port i_mixw_reg_port (
        .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .xfer_stop(xfer_stop),
        .wr_valid(wr_valid), .wr_byte(wr_byte), .rd_req(rd_req),
        .rd_valid(rd_valid), .rd_byte(rd_byte), .ctrl_word(ctrl_word));

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] bo(input logic [31:0] d, input int k);
        case (k)
            0:       return d[15:8];
            1:       return d[7:0];
            2:       return d[31:24];
            default: return d[23:16];
        endcase
    endfunction

    task automatic go_start();
        xfer_start = 1'b1; @(negedge clk); xfer_start = 1'b0;
    endtask

    task automatic go_stop();
        xfer_stop = 1'b1; @(negedge clk); xfer_stop = 1'b0;
    endtask

    task automatic put(input logic [7:0] b);
        wr_valid = 1'b1; wr_byte = b; @(negedge clk); wr_valid = 1'b0;
    endtask

    task automatic get(output logic [7:0] b);
        rd_req = 1'b1; @(negedge clk); rd_req = 1'b0;
        chk(rd_valid === 1'b1, "R4 rd_valid", 32'(rd_valid), 32'h1);
        b = rd_byte;
    endtask

    task automatic put_ptr(input logic [15:0] a);
        put(a[15:8]); put(a[7:0]);
    endtask

    task automatic wr_reg(input logic [15:0] a, input int n, input logic [31:0] d);
        go_start(); put_ptr(a);
        for (int k = 0; k < n; k++) put(bo(d, k));
        go_stop();
    endtask

    task automatic rd_reg(input logic [15:0] a, input int n, output logic [31:0] v);
        logic [7:0] b;
        v = '0;
        go_start(); put_ptr(a); go_start();
        for (int k = 0; k < n; k++) begin
            get(b);
            case (k)
                0: v[15:8]  = b;
                1: v[7:0]   = b;
                2: v[31:24] = b;
                default: v[23:16] = b;
            endcase
        end
        go_stop();
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk(rd_valid === 1'b0, "R12 rd_valid", 32'(rd_valid), 0);
        chk(ctrl_word === 16'h0, "R12 ctrl_word", 32'(ctrl_word), 0);
        rd_reg(16'h0000, 2, v); chk(v == 0, "R12 reg 0x0000", v, 0);
        rd_reg(16'h0200, 4, v); chk(v == 0, "R12 reg 0x0200", v, 0);
    endtask

    task automatic t_narrow_wide();
        logic [31:0] v;
        logic [7:0]  b;
        wr_reg(16'h0002, 2, 32'h0000BEEF);
        rd_reg(16'h0002, 2, v); chk(v == 32'hBEEF, "R1 R2 narrow 0x0002", v, 32'hBEEF);
        wr_reg(16'h0606, 2, 32'h00001234);
        rd_reg(16'h0606, 2, v); chk(v == 32'h1234, "R2 narrow 0x0606", v, 32'h1234);
        // wire order C3 D4 A1 B2 for word A1B2C3D4
        go_start(); put_ptr(16'h0204); put(8'hC3); put(8'hD4); put(8'hA1); put(8'hB2); go_stop();
        go_start(); put_ptr(16'h0204); go_start();
        get(b); chk(b == 8'hC3, "R4 byte0", 32'(b), 32'hC3);
        get(b); chk(b == 8'hD4, "R4 byte1", 32'(b), 32'hD4);
        get(b); chk(b == 8'hA1, "R4 byte2", 32'(b), 32'hA1);
        get(b); chk(b == 8'hB2, "R4 byte3", 32'(b), 32'hB2);
        go_stop();
        rd_reg(16'h0204, 4, v); chk(v == 32'hA1B2C3D4, "R3 wide 0x0204", v, 32'hA1B2C3D4);
    endtask

    task automatic t_burst();
        logic [31:0] v, w;
        go_start(); put_ptr(16'h0200);
        for (int k = 0; k < 4; k++) put(bo(32'h01020304, k));
        for (int k = 0; k < 4; k++) put(bo(32'h05060708, k));
        go_stop();
        rd_reg(16'h0204, 4, v); chk(v == 32'h05060708, "R9 burst second wide", v, 32'h05060708);
        begin
            logic [7:0] b;
            go_start(); put_ptr(16'h0200); go_start();
            v = '0; w = '0;
            for (int k = 0; k < 8; k++) begin
                get(b);
                if (k < 4) v = v | (32'(b) << ((k == 0) ? 8 : (k == 1) ? 0 : (k == 2) ? 24 : 16));
                else w = w | (32'(b) << ((k == 4) ? 8 : (k == 5) ? 0 : (k == 6) ? 24 : 16));
            end
            go_stop();
        end
        chk(v == 32'h01020304, "R9 read burst first", v, 32'h01020304);
        chk(w == 32'h05060708, "R9 read burst second", w, 32'h05060708);
        // wide unmapped at 0x05FC then narrow at 0x0600
        go_start(); put_ptr(16'h05FC);
        put(8'h11); put(8'h22); put(8'h33); put(8'h44); put(8'h55); put(8'h66);
        go_stop();
        rd_reg(16'h0600, 2, v); chk(v == 32'h5566, "R9 R2 width switch", v, 32'h5566);
        rd_reg(16'h0602, 2, v); chk(v == 0, "R9 no spill 0x0602", v, 0);
    endtask

    task automatic t_partial();
        logic [31:0] v;
        logic [7:0]  b;
        wr_reg(16'h0208, 4, 32'h11223344);
        go_start(); put_ptr(16'h0208); put(8'hAA); put(8'hBB); put(8'hCC); go_stop();
        rd_reg(16'h0208, 4, v); chk(v == 32'h11223344, "R8 stop mid word", v, 32'h11223344);
        wr_reg(16'h0000, 2, 32'h00005A5A);
        go_start(); put_ptr(16'h0000); put(8'hFF); go_start();
        get(b); v[15:8] = b; get(b); v[7:0] = b; go_stop();
        chk(v[15:0] == 16'h5A5A, "R8 R10 restart keeps ptr", 32'(v[15:0]), 32'h5A5A);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        rd_reg(16'h0100, 4, v); chk(v == 0, "R5 0x0100", v, 0);
        wr_reg(16'h0008, 2, 32'h0000FFFF);
        rd_reg(16'h0008, 2, v); chk(v == 0, "R5 0x0008", v, 0);
        rd_reg(16'h0006, 2, v); chk(v == 0, "R5 neighbour 0x0006", v, 0);
    endtask

    task automatic t_indirect();
        logic [31:0] v;
        wr_reg(16'h0500, 4, 32'hA30080A7);
        chk(ctrl_word == 16'h80A7, "R6 set", 32'(ctrl_word), 32'h80A7);
        rd_reg(16'h040C, 4, v); chk(v == 32'h000080A7, "R7 readback", v, 32'h80A7);
        wr_reg(16'h0500, 4, 32'hC3000007);
        chk(ctrl_word == 16'h80A0, "R6 clear", 32'(ctrl_word), 32'h80A0);
        wr_reg(16'h0500, 4, 32'hA200FFFF);
        chk(ctrl_word == 16'h80A0, "R6 other target", 32'(ctrl_word), 32'h80A0);
        wr_reg(16'h0500, 4, 32'hE300FFFF);
        chk(ctrl_word == 16'h80A0, "R6 other op", 32'(ctrl_word), 32'h80A0);
        wr_reg(16'h040C, 4, 32'hFFFFFFFF);
        chk(ctrl_word == 16'h80A0, "R7 direct write", 32'(ctrl_word), 32'h80A0);
        rd_reg(16'h0500, 4, v); chk(v == 0, "R5 indirect reads zero", v, 0);
    endtask

    task automatic t_idle();
        logic [31:0] v;
        put(8'h00); put(8'h02); put(8'h00); put(8'h00);
        rd_req = 1'b1; @(negedge clk); rd_req = 1'b0;
        chk(rd_valid === 1'b0, "R11 idle read", 32'(rd_valid), 0);
        rd_reg(16'h0002, 2, v); chk(v == 32'hBEEF, "R11 idle write", v, 32'hBEEF);
    endtask

    initial begin
        repeat (100000) @(negedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_narrow_wide();
        t_burst();
        t_partial();
        t_unmapped();
        t_indirect();
        t_idle();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule